// File: doc/BRIEF.md
# Quad-Pumped Source-Synchronous Bus Receiver with Lane Polarity Recovery

This block takes in a 64-bit source-synchronous data bus that moves four data beats during every period of the common clock. The bus is split into four 16-bit lanes. Each lane has its own pair of interleaved strobes and its own polarity flag. All bus pins are active low. On each falling edge of a lane's strobes the block captures that lane's 16 bits. If the lane's polarity flag was asserted on that same edge, the block also undoes the sender's inversion.

When the ready input is seen asserted at a rising edge of the common clock, the four beats of all four lanes are assembled into one 256-bit line. That line is registered into the clock domain and announced by a one-cycle valid pulse. Whenever ready is deasserted, the beat pointers are cleared. A burst that stops early is therefore thrown away and cannot shift the beats of the next burst.

Top module: `qp_bus_rx`

## Requirements
- R1: Lane l (l = 0..3) is carried on `bus_n[16l+15:16l]` and is captured only by `stb_p_n[l]` and `stb_n_n[l]`. It is qualified only by `inv_n[l]`.
- R2: Within a burst, falling edges of a lane's P strobe deliver beats 0 and 2, in that order. Falling edges of its N strobe deliver beats 1 and 3. Beat b of lane l appears at `line_data[64b+16l+15 : 64b+16l]`.
- R3: Pins are active low. With `inv_n[l]` high (not inverting), the recovered value is the complement of the pins. With `inv_n[l]` low (inverting), the recovered value equals the pins.
- R4: The polarity flag is sampled on the same strobe edge as the beat it qualifies. Each of the four beats of a lane may use a different flag value.
- R5: If `rdy_n` is sampled low at a rising clock edge, `line_valid` is high during the following cycle only, and `line_data` holds the newly assembled line.
- R6: While `line_valid` is low, `line_data` keeps its previous value.
- R7: While `rdy_n` is high, the beat pointers are held cleared. A burst of 1 to 3 beats that ends with `rdy_n` deasserted produces no valid pulse, and the next full burst is assembled correctly.
- R8: With `rst` high at a rising edge (synchronous, active high), the next cycle shows `line_valid` low and `line_data` all zeros.
- R9: Full bursts on consecutive clock periods with `rdy_n` held low produce one valid pulse per period, each carrying its own burst's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_n | input | 64 | Active-low data pins, four 16-bit lanes |
| stb_p_n | input | 4 | Per-lane P strobes; falling edge captures beats 0 and 2 |
| stb_n_n | input | 4 | Per-lane N strobes; falling edge captures beats 1 and 3 |
| inv_n | input | 4 | Per-lane active-low polarity flag, sampled with each beat |
| rdy_n | input | 1 | Active-low ready; marks a valid transfer, clears beat pointers while high |
| line_data | output | 256 | Assembled 256-bit line, beat 0 in the low 64 bits |
| line_valid | output | 1 | One-cycle pulse when a new line is presented |

## Verification
The polarity flags are swept through sixteen patterns per lane and per beat, with a different pattern on each beat. This separates per-beat sampling from per-burst sampling and catches swapped polarity sense. All-zero and all-one data with uniform flags isolate the polarity rule from data ordering. Random data, with each lane's strobes skewed slightly from its neighbours, shows whether beats land in the right slot and the right lane. Partial bursts of one, two and three beats followed by a full burst, back-to-back bursts, idle gaps and a mid-stream reset probe pointer clearing, the valid pulse width and data hold.

// File: rtl/qpr_pkg.sv
`timescale 1ns/100ps
package qpr_pkg;
  // falling edges delivered by one strobe within a burst
  localparam int unsigned EDGES_PER_STROBE = 2;
  // strobes per lane: P (even beats) and N (odd beats)
  localparam int unsigned STROBES_PER_LANE = 2;

  // active-low pin with active-low inversion flag -> true bit
  function automatic logic undo_polarity(input logic pin, input logic flag_n);
    return flag_n ? ~pin : pin;
  endfunction
endpackage

// File: rtl/qpr_strobe_cap.sv
`timescale 1ns/100ps
module qpr_strobe_cap #(
  parameter int unsigned LANE_W = 16,
  parameter int unsigned EDGES  = qpr_pkg::EDGES_PER_STROBE,
  localparam int unsigned PW    = (EDGES > 1) ? $clog2(EDGES) : 1
) (
  input  logic                    stb_n,
  input  logic                    clr,
  input  logic [LANE_W-1:0]       pin,
  input  logic                    flag_n,
  output logic [EDGES*LANE_W-1:0] slots,
  output logic [PW-1:0]           ptr
);
  logic [LANE_W-1:0] fixed;

  always_comb begin
    for (int i = 0; i < int'(LANE_W); i++)
      fixed[i] = qpr_pkg::undo_polarity(pin[i], flag_n);
  end

  // edge pointer: held at zero while the clear is active
  always_ff @(negedge stb_n or posedge clr) begin
    if (clr)
      ptr <= '0;
    else if (ptr == PW'(EDGES - 1))
      ptr <= '0;
    else
      ptr <= ptr + 1'b1;
  end

  // capture slots, no reset so they map onto plain flops
  always_ff @(negedge stb_n) begin
    slots[ptr*LANE_W +: LANE_W] <= fixed;
  end
endmodule

// File: rtl/qpr_lane.sv
`timescale 1ns/100ps
module qpr_lane #(
  parameter int unsigned LANE_W = 16,
  parameter int unsigned EDGES  = qpr_pkg::EDGES_PER_STROBE,
  localparam int unsigned SIDES = qpr_pkg::STROBES_PER_LANE,
  localparam int unsigned BEATS = SIDES * EDGES,
  localparam int unsigned PW    = (EDGES > 1) ? $clog2(EDGES) : 1
) (
  input  logic                    stb_p_n,
  input  logic                    stb_n_n,
  input  logic                    clr,
  input  logic [LANE_W-1:0]       pin,
  input  logic                    flag_n,
  output logic [BEATS*LANE_W-1:0] beats,
  output logic [SIDES*PW-1:0]     ptrs
);
  logic [SIDES-1:0] stb;
  assign stb = {stb_n_n, stb_p_n};

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    logic [EDGES*LANE_W-1:0] side_slots;
    logic [PW-1:0]           side_ptr;

    qpr_strobe_cap #(.LANE_W(LANE_W), .EDGES(EDGES)) u_cap (
      .stb_n  (stb[s]),
      .clr    (clr),
      .pin    (pin),
      .flag_n (flag_n),
      .slots  (side_slots),
      .ptr    (side_ptr)
    );

    assign ptrs[s*PW +: PW] = side_ptr;

    // edge k of side s carries beat (SIDES*k + s)
    for (genvar k = 0; k < EDGES; k++) begin : g_edge
      assign beats[(SIDES*k + s)*LANE_W +: LANE_W] = side_slots[k*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/qpr_line_reg.sv
`timescale 1ns/100ps
module qpr_line_reg #(
  parameter int unsigned LINE_W = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [LINE_W-1:0] d,
  output logic [LINE_W-1:0] q,
  output logic              valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      q     <= '0;
    end else begin
      valid <= take;
      if (take)
        q <= d;
    end
  end

  assert_valid_follows_ready_R5: assert property (@(posedge clk) disable iff (rst)
    valid |-> $past(take));

  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (!valid && !$past(rst)) |-> $stable(q));

  assert_reset_clears_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!valid && q == '0));
endmodule

// File: rtl/qp_bus_rx.sv
`timescale 1ns/100ps
module qp_bus_rx #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 16,
  parameter int unsigned EDGES  = qpr_pkg::EDGES_PER_STROBE,
  localparam int unsigned BUS_W  = LANES * LANE_W,
  localparam int unsigned BEATS  = qpr_pkg::STROBES_PER_LANE * EDGES,
  localparam int unsigned LINE_W = BEATS * BUS_W,
  localparam int unsigned PW     = (EDGES > 1) ? $clog2(EDGES) : 1,
  localparam int unsigned LPW    = qpr_pkg::STROBES_PER_LANE * PW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_W-1:0]  bus_n,
  input  logic [LANES-1:0]  stb_p_n,
  input  logic [LANES-1:0]  stb_n_n,
  input  logic [LANES-1:0]  inv_n,
  input  logic              rdy_n,
  output logic [LINE_W-1:0] line_data,
  output logic              line_valid
);
  logic                    clr;
  logic [LINE_W-1:0]       line_next;
  logic [LANES*LPW-1:0]    ptr_all;

  // pointers cleared by reset or by ready deasserted
  assign clr = rst | rdy_n;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BEATS*LANE_W-1:0] lane_beats;

    qpr_lane #(.LANE_W(LANE_W), .EDGES(EDGES)) u_lane (
      .stb_p_n (stb_p_n[l]),
      .stb_n_n (stb_n_n[l]),
      .clr     (clr),
      .pin     (bus_n[l*LANE_W +: LANE_W]),
      .flag_n  (inv_n[l]),
      .beats   (lane_beats),
      .ptrs    (ptr_all[l*LPW +: LPW])
    );

    for (genvar b = 0; b < BEATS; b++) begin : g_beat
      assign line_next[b*BUS_W + l*LANE_W +: LANE_W] = lane_beats[b*LANE_W +: LANE_W];
    end
  end

  qpr_line_reg #(.LINE_W(LINE_W)) u_line (
    .clk   (clk),
    .rst   (rst),
    .take  (~rdy_n),
    .d     (line_next),
    .q     (line_data),
    .valid (line_valid)
  );

  // idle bus: every strobe pointer sits at its first edge
  assert_ptr_idle_R7: assert property (@(posedge clk) disable iff (rst)
    rdy_n |-> (ptr_all == '0));

  // a completed burst returns every pointer to its first edge
  assert_burst_complete_R2: assert property (@(posedge clk) disable iff (rst)
    (!rdy_n) |-> (ptr_all == '0));
endmodule

// File: tb/qp_bus_rx_test.sv
`timescale 1ns/100ps
module qp_bus_rx_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [63:0]  bus_n = '1;
  logic [3:0]   stb_p_n = '1;
  logic [3:0]   stb_n_n = '1;
  logic [3:0]   inv_n = '1;
  logic         rdy_n = 1'b1;
  logic [255:0] line_data;
  logic         line_valid;

  int n_checks = 0;
  int n_fail   = 0;

  logic [255:0] exp_line  = '0;
  logic         exp_valid = 1'b0;
  string        chk_tag   = "R8";

  always #10 clk = ~clk;  // 50 MHz

  qp_bus_rx uut (
    .clk(clk), .rst(rst), .bus_n(bus_n), .stb_p_n(stb_p_n), .stb_n_n(stb_n_n),
    .inv_n(inv_n), .rdy_n(rdy_n), .line_data(line_data), .line_valid(line_valid)
  );

  task automatic check_bit(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s line_valid actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic check_line(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s line_data actual=%h expected=%h", req, act, exp);
    end
  endtask

  // mode 0 idle, 1 burst of nbeats, 2 reset; dk 0 random, 1 zeros, 2 ones
  task automatic run_cycle(input int mode, input int nbeats, input logic [15:0] invmap,
                           input int dk, input string tag);
    logic [255:0] nxt;
    nxt = exp_line;
    @(posedge clk);
    #2;
    check_bit(chk_tag, line_valid, exp_valid);
    check_line(chk_tag, line_data, exp_line);
    rst   = (mode == 2);
    rdy_n = (mode != 1);
    chk_tag   = tag;
    exp_valid = 1'b0;
    if (mode == 2) exp_line = '0;
    if (mode == 1) begin
      for (int b = 0; b < nbeats; b++) begin
        for (int l = 0; l < 4; l++) begin
          logic [15:0] v;
          logic        f;
          v = (dk == 0) ? 16'($urandom) : (dk == 1) ? 16'h0000 : 16'hFFFF;
          f = invmap[b*4 + l];
          // R3: inverted lane arrives uncomplemented on active-low pins
          bus_n[l*16 +: 16] = f ? v : ~v;
          inv_n[l] = ~f;
          nxt[b*64 + l*16 +: 16] = v;
        end
        #1;
        // R1: lanes strobed with small skew so a lane/strobe mixup shows
        for (int l = 0; l < 4; l++) begin
          if (b % 2 == 0) stb_p_n[l] = 1'b0;
          else            stb_n_n[l] = 1'b0;
          #0.4;
        end
        #0.4;
        stb_p_n = '1;
        stb_n_n = '1;
        #1;
      end
      if (nbeats == 4) begin
        exp_valid = 1'b1;
        exp_line  = nxt;
      end else begin
        rdy_n = 1'b1;  // R7: abandon partial burst
      end
    end
  endtask

  initial begin
    #(20ns * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    // R8: first check sees the reset state
    // R3: uniform data, uniform polarity
    run_cycle(1, 4, 16'h0000, 1, "R3");
    run_cycle(1, 4, 16'hFFFF, 1, "R3");
    run_cycle(1, 4, 16'h0000, 2, "R3");
    run_cycle(1, 4, 16'hFFFF, 2, "R3");
    // R4: per-lane, per-beat polarity sweep
    for (int k = 0; k < 16; k++) begin
      logic [15:0] m;
      for (int b = 0; b < 4; b++) m[b*4 +: 4] = 4'(k) ^ 4'(5 * b);
      run_cycle(1, 4, m, 0, "R4");
    end
    // R5 / R6: idle after a burst -> pulse ends, data held
    run_cycle(0, 0, 16'h0, 0, "R5");
    run_cycle(0, 0, 16'h0, 0, "R6");
    // R2 / R1: random data, random polarity
    for (int i = 0; i < 8; i++) run_cycle(1, 4, 16'($urandom), 0, "R2");
    run_cycle(0, 0, 16'h0, 0, "R6");
    // R7: partial bursts discarded, next burst aligned
    for (int n = 1; n < 4; n++) begin
      run_cycle(1, n, 16'($urandom), 0, "R7");
      run_cycle(1, 4, 16'($urandom), 0, "R7");
      run_cycle(0, 0, 16'h0, 0, "R6");
    end
    // R9: back-to-back bursts with ready held low
    for (int i = 0; i < 6; i++) run_cycle(1, 4, 16'($urandom), 0, "R9");
    // R8: reset in mid stream
    run_cycle(2, 0, 16'h0, 0, "R8");
    run_cycle(1, 4, 16'($urandom), 0, "R1");
    run_cycle(0, 0, 16'h0, 0, "R5");
    run_cycle(0, 0, 16'h0, 0, "R6");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule